// File: doc/BRIEF.md
# Decrement-and-Branch Loop Unit

This unit carries out the loop-closing instruction of a small processor with a 16-bit address space, together with the few moves that set a loop up. A counter-bank holds the loop counters. Executing the loop instruction subtracts one from a selected counter and writes the result back. If the result is not zero, the instruction pointer moves to a branch target. If it is zero, execution falls through to the next address.

The branch target can come from three places. The first is a signed 8-bit displacement added to the address of the following instruction. The second is an 8-bit low byte placed under a high byte held in a one-shot prefix register. The third is a full 16-bit value read from another counter that is being used as an address holder. Counters can be loaded from a 16-bit immediate or from the address of the next instruction, so a loop target can be captured just before the top of the loop.

The unit keeps the instruction pointer itself. Its outputs are registered: the pointer, a one-cycle taken flag, and the counter value most recently written by a loop instruction.

Top module: `loop_branch_unit`

## Requirements
- R1: When `op_valid` is high and `op_code` is 1 (loop instruction), counter `cnt_sel` is replaced by its value minus one, and `cnt_out` shows that new value after the edge. `br_taken` is 1 after the edge exactly when the new value is nonzero.
- R2: An instruction that does not branch moves `ip` to `ip`+1 (modulo 2^16). This covers a loop instruction whose result is zero, and also op codes 0 and 2 to 7. While `op_valid` is low, `ip` holds, `br_taken` is 0 and no state changes.
- R3: With `src_kind` = 0, the branch target is (`ip`+1) plus `operand[7:0]`, sign-extended to 16 bits.
- R4: With `src_kind` = 1, the branch target is {prefix, `operand[7:0]`}, where prefix is the byte written by op code 4 in the instruction immediately before. If there was no such write, the prefix is 00h.
- R5: The prefix written by op code 4 (`operand[7:0]`) is used by the next valid instruction only. Any valid instruction other than op code 4 clears it back to 00h. Cycles with `op_valid` low do not clear it.
- R6: With `src_kind` = 2 or 3, the branch target is the full 16-bit value of counter `src_sel`, read before this instruction's write. The prefix plays no part.
- R7: Op code 2 loads counter `cnt_sel` with `operand`.
- R8: Op code 3 loads counter `cnt_sel` with `ip`+1, the address of the following instruction.
- R9: Synchronous reset sets `ip` to `RESET_IP` (default 0000h), every counter to 0, the prefix to 00h, `br_taken` to 0 and `cnt_out` to 0.
- R10: A counter loaded with 10h, closing a loop that branches back to itself, branches 15 times and falls through on the 16th execution, so the loop body runs 16 times.
- R11: A loop instruction on a counter holding 0 wraps it to FFFFh and branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented in this cycle |
| op_code | input | 3 | 0 none, 1 loop, 2 load immediate, 3 load next address, 4 write prefix |
| cnt_sel | input | 2 | Counter that is decremented or loaded |
| src_kind | input | 2 | Target source: 0 relative, 1 prefix + byte, 2 or 3 counter |
| src_sel | input | 2 | Counter that supplies a 16-bit target |
| operand | input | 16 | Immediate value, displacement byte or low byte |
| ip | output | 16 | Registered instruction pointer |
| br_taken | output | 1 | The last instruction branched |
| cnt_out | output | 16 | Counter value last written by a loop instruction |

## Verification
The assertions assume that the instruction fields are steady and meaningful whenever `op_valid` is high. They also assume that `cnt_sel` and `src_sel` name one of the implemented counters. The stimulus meets these assumptions by driving every field at the falling edge, one instruction per cycle, and by drawing selects only from the four counters that exist. Idle cycles hold `op_valid` low. They are used on purpose to show that the pointer holds and that a pending prefix survives them.

// File: rtl/loop_pkg.sv
package loop_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_LOOP = 3'd1,
    OP_LDI  = 3'd2,
    OP_LDIP = 3'd3,
    OP_PFX  = 3'd4
  } lbu_op_e;

  localparam logic [1:0] SRC_REL = 2'd0;
  localparam logic [1:0] SRC_PFX = 2'd1;
endpackage

// File: rtl/lbu_cnt_bank.sv
module lbu_cnt_bank #(
  parameter int NUM = 4,
  parameter int W   = 16,
  localparam int SW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] raddr_a,
  input  logic [SW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                             regs[g] <= '0;
      else if (we && (waddr == SW'(g)))    regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/lbu_prefix.sv
module lbu_prefix #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          wr,
  input  logic [HW-1:0] din,
  output logic [HW-1:0] hi
);
  always_ff @(posedge clk) begin
    if (rst)        hi <= '0;
    else if (valid) hi <= wr ? din : '0;
  end

  AST_PFX_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    (valid && !wr) |=> (hi == '0)); // R5
  AST_PFX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (valid && wr) |=> (hi == $past(din))); // R4
  AST_PFX_KEEP: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(hi)); // R5
endmodule

// File: rtl/lbu_target.sv
module lbu_target #(
  parameter int AW = 16,
  localparam int HW = AW - 8
) (
  input  logic [1:0]    src_kind,
  input  logic [AW-1:0] next_ip,
  input  logic [7:0]    lo_byte,
  input  logic [HW-1:0] pfx_hi,
  input  logic [AW-1:0] reg_val,
  output logic [AW-1:0] target
);
  import loop_pkg::*;

  logic [AW-1:0] disp_ext;
  assign disp_ext = {{(AW-8){lo_byte[7]}}, lo_byte};

  always_comb begin
    unique case (src_kind)
      SRC_REL: target = next_ip + disp_ext;
      SRC_PFX: target = {pfx_hi, lo_byte};
      default: target = reg_val;
    endcase
  end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit #(
  parameter int              NUM_CNT  = 4,
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   RESET_IP = '0,
  localparam int             SEL_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int             HW       = AW - 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [SEL_W-1:0] cnt_sel,
  input  logic [1:0]       src_kind,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [AW-1:0]    operand,
  output logic [AW-1:0]    ip,
  output logic             br_taken,
  output logic [AW-1:0]    cnt_out
);
  import loop_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);

  lbu_op_e        op;
  logic [AW-1:0]  cnt_val, src_val, dec_val, next_ip, target, wdata;
  logic [HW-1:0]  pfx_hi;
  logic           is_loop, we, take;

  assign op      = lbu_op_e'(op_code);
  assign is_loop = op_valid && (op == OP_LOOP);
  assign next_ip = ip + ONE;
  assign dec_val = cnt_val - ONE;
  assign take    = is_loop && (dec_val != '0);

  always_comb begin
    we    = 1'b0;
    wdata = dec_val;
    if (op_valid) begin
      unique case (op)
        OP_LOOP: we = 1'b1;
        OP_LDI:  begin we = 1'b1; wdata = operand; end
        OP_LDIP: begin we = 1'b1; wdata = next_ip; end
        default: we = 1'b0;
      endcase
    end
  end

  lbu_cnt_bank #(.NUM(NUM_CNT), .W(AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .waddr   (cnt_sel),
    .wdata   (wdata),
    .raddr_a (cnt_sel),
    .raddr_b (src_sel),
    .rdata_a (cnt_val),
    .rdata_b (src_val)
  );

  lbu_prefix #(.HW(HW)) u_pfx (
    .clk   (clk),
    .rst   (rst),
    .valid (op_valid),
    .wr    (op == OP_PFX),
    .din   (operand[HW-1:0]),
    .hi    (pfx_hi)
  );

  lbu_target #(.AW(AW)) u_tgt (
    .src_kind (src_kind),
    .next_ip  (next_ip),
    .lo_byte  (operand[7:0]),
    .pfx_hi   (pfx_hi),
    .reg_val  (src_val),
    .target   (target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ip       <= RESET_IP;
      br_taken <= 1'b0;
      cnt_out  <= '0;
    end else begin
      br_taken <= take;
      if (op_valid) ip <= take ? target : next_ip;
      if (is_loop)  cnt_out <= dec_val;
    end
  end

  AST_IP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(ip) && !br_taken)); // R2
  AST_TAKEN_FROM_LOOP: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> $past(op_valid && (op_code == 3'd1))); // R1
  AST_TAKEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (cnt_out != '0)); // R1
  AST_LAST_PASS_FALLS: assert property (@(posedge clk) disable iff (rst)
    (is_loop && (cnt_val == ONE)) |=> (!br_taken && ip == $past(ip) + ONE)); // R2
endmodule

// File: tb/loop_branch_unit_tb.sv
module loop_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  cnt_sel = '0;
  logic [1:0]  src_kind = '0;
  logic [1:0]  src_sel = '0;
  logic [15:0] operand = '0;
  logic [15:0] ip;
  logic        br_taken;
  logic [15:0] cnt_out;

  always #2 clk = ~clk;

  loop_branch_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .cnt_sel(cnt_sel), .src_kind(src_kind), .src_sel(src_sel),
    .operand(operand), .ip(ip), .br_taken(br_taken), .cnt_out(cnt_out)
  );

  typedef struct {
    logic [15:0] ip;
    logic        tk;
    logic [15:0] cnt;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] m_ip = '0;
  logic [15:0] m_cnt [4] = '{default: '0};
  logic [7:0]  m_pfx = '0;
  logic [15:0] m_out = '0;

  task automatic issue(input logic v, input logic [2:0] opc, input logic [1:0] cs,
                       input logic [1:0] sk, input logic [1:0] ss,
                       input logic [15:0] opd, input string tag);
    exp_t        e;
    logic [15:0] nxt, tgt, d, rv;
    logic        tk;
    @(negedge clk);
    op_valid = v; op_code = opc; cnt_sel = cs; src_kind = sk;
    src_sel = ss; operand = opd;
    tk = 1'b0;
    if (v) begin
      nxt = m_ip + 16'd1;
      rv  = m_cnt[ss];
      case (opc)
        3'd1: begin
          d = m_cnt[cs] - 16'd1;
          m_cnt[cs] = d;
          m_out = d;
          if (sk == 2'd0)      tgt = nxt + {{8{opd[7]}}, opd[7:0]};
          else if (sk == 2'd1) tgt = {m_pfx, opd[7:0]};
          else                 tgt = rv;
          tk = (d != 16'd0);
        end
        3'd2: m_cnt[cs] = opd;
        3'd3: m_cnt[cs] = nxt;
        default: ;
      endcase
      m_ip  = tk ? tgt : nxt;
      m_pfx = (opc == 3'd4) ? opd[7:0] : 8'h00;
    end
    e.ip = m_ip; e.tk = tk; e.cnt = m_out; e.tag = tag;
    sb_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (ip !== e.ip || br_taken !== e.tk || cnt_out !== e.cnt) begin
        n_bad++;
        $display("FAIL %s: ip=%h tk=%b cnt=%h expected ip=%h tk=%b cnt=%h",
                 e.tag, ip, br_taken, cnt_out, e.ip, e.tk, e.cnt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (ip !== 16'h0000 || br_taken !== 1'b0 || cnt_out !== 16'h0000) begin
      n_bad++;
      $display("FAIL R9: ip=%h tk=%b cnt=%h expected 0000 0 0000", ip, br_taken, cnt_out);
    end
    // R11 / R9: counter 0 resets to zero, wraps to FFFF, relative +5
    issue(1, 3'd1, 2'd0, 2'd0, 2'd0, 16'h0005, "R11");
    // R7: load 10h
    issue(1, 3'd2, 2'd1, 2'd0, 2'd0, 16'h0010, "R7");
    // R10: self loop, displacement -1
    for (int i = 0; i < 16; i++) issue(1, 3'd1, 2'd1, 2'd0, 2'd0, 16'h00FF, "R10");
    // R4: prefix + low byte
    issue(1, 3'd4, 2'd0, 2'd0, 2'd0, 16'h0012, "R5");
    issue(1, 3'd1, 2'd2, 2'd1, 2'd0, 16'h0034, "R4");
    // R5: prefix gone, high byte 00
    issue(1, 3'd1, 2'd2, 2'd1, 2'd0, 16'h0056, "R5");
    // R8: capture next address
    issue(1, 3'd3, 2'd3, 2'd0, 2'd0, 16'hFFFF, "R8");
    // R6: register target, prefix pending but ignored
    issue(1, 3'd4, 2'd0, 2'd0, 2'd0, 16'h00AB, "R5");
    issue(1, 3'd1, 2'd2, 2'd2, 2'd3, 16'h0000, "R6");
    // R2: idle cycles hold
    issue(0, 3'd1, 2'd0, 2'd0, 2'd0, 16'h0000, "R2");
    issue(0, 3'd2, 2'd0, 2'd0, 2'd0, 16'h1111, "R2");
    // R1: count 1 -> 0 falls through
    issue(1, 3'd2, 2'd1, 2'd0, 2'd0, 16'h0001, "R7");
    issue(1, 3'd1, 2'd1, 2'd0, 2'd0, 16'h0040, "R1");
    // R3: large negative displacement
    issue(1, 3'd2, 2'd0, 2'd0, 2'd0, 16'h0300, "R7");
    issue(1, 3'd1, 2'd0, 2'd0, 2'd0, 16'h0080, "R3");
    issue(1, 3'd1, 2'd0, 2'd0, 2'd0, 16'h007F, "R3");
    // R5: prefix survives an idle cycle, then used
    issue(1, 3'd4, 2'd0, 2'd0, 2'd0, 16'h00C0, "R5");
    issue(0, 3'd0, 2'd0, 2'd0, 2'd0, 16'h0000, "R2");
    issue(1, 3'd1, 2'd0, 2'd1, 2'd0, 16'h0011, "R4");
    // R2: other op codes just advance
    issue(1, 3'd5, 2'd0, 2'd0, 2'd0, 16'h0000, "R2");
    issue(1, 3'd0, 2'd0, 2'd0, 2'd0, 16'h0000, "R2");
    // R6 with src_kind 3 using counter 0
    issue(1, 3'd2, 2'd3, 2'd0, 2'd0, 16'h0009, "R7");
    issue(1, 3'd1, 2'd3, 2'd3, 2'd0, 16'h0000, "R6");
    issue(0, 3'd0, 2'd0, 2'd0, 2'd0, 16'h0000, "R2");
    while (sb_q.size() > 0) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule